// File: doc/BRIEF.md
# Alternate-Space Access Checker and Formatter

This block sits in front of a load/store unit and prepares every alternate-space access before it reaches memory. Each request carries an 8-bit space number, a size of 1, 2, 4 or 8 bytes, a signed-load flag, the supervisor and hypervisor privilege flags, an address and a 64-bit data word. For a store, the data word is the value to be written. For a load, it is the raw value returned by memory.

The block checks privilege in the same cycle as the request and raises a trap when the access is not allowed. For a permitted request it does three things. It swaps the bytes for spaces that are defined as little-endian. It sign-extends narrow signed loads. On stores it clears the low address bits to natural alignment and marks bypass spaces for physical addressing. The formatted result appears one cycle later with a single-cycle valid pulse. A trapped request produces no pulse.

Top module: `asi_access_fmt`

## Requirements
- R1: A request whose space number is below 0x80 raises `trap_priv` when `priv_sup` is 0.
- R2: A request whose space number lies in 0x30..0x7F raises `trap_priv` when `priv_hyp` is 0, even with `priv_sup` set. Spaces 0x80 and above never trap.
- R3: `trap_priv` is combinational in the request cycle and is 0 when `req_valid` is 0. A trapped request produces no `res_valid` in the next cycle.
- R4: A request that does not trap gives `res_valid` = 1 in exactly the following cycle, for one cycle only. `res_store` echoes the access direction.
- R5: On loads (`req_store` = 0), spaces 0x0C, 0x18, 0x19, 0x1C, 0x1D, 0x88, 0x89, 0x8A and 0x8B reverse the byte order of the low N bytes, where N is the access size.
- R6: On stores, the little-endian set is the load set without 0x8A and 0x8B. A store to 0x8A or 0x8B keeps its bytes in order.
- R7: `req_size` encodes 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = 8 bytes. A 1-byte access is never swapped. Bytes above the access size are zero in `res_data`, unless R8 applies.
- R8: A load with `req_signed` = 1 and a size of 1, 2 or 4 bytes fills `res_data` above the size with copies of the top bit of the access. An 8-byte load and all stores are not extended.
- R9: On a little-endian signed load, the sign bit is taken after the swap, from the top byte of the swapped value.
- R10: For stores, `res_addr` equals `req_addr` with its low 1, 2 or 3 bits cleared for sizes of 2, 4 and 8 bytes. For loads and 1-byte stores, `res_addr` equals `req_addr`.
- R11: `res_phys` is 1 only for stores to spaces 0x14, 0x15, 0x1C and 0x1D.
- R12: After reset, `res_valid`, `res_data`, `res_addr`, `res_phys` and `res_store` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_space | input | 8 | Address-space number |
| req_size | input | 2 | Access size code (see R7) |
| req_signed | input | 1 | Sign-extend a load |
| priv_sup | input | 1 | Supervisor privilege flag |
| priv_hyp | input | 1 | Hypervisor privilege flag |
| req_addr | input | ADDR_W | Access address |
| req_data | input | DATA_W | Store data or raw load data |
| trap_priv | output | 1 | Privileged-action trap, same cycle |
| res_valid | output | 1 | Formatted result valid (memory strobe) |
| res_store | output | 1 | Direction of the result |
| res_phys | output | 1 | Store uses physical addressing |
| res_addr | output | ADDR_W | Formatted address |
| res_data | output | DATA_W | Formatted data |

## Verification
A wrong privilege decode shows up on `trap_priv` in the same cycle as the request. One cycle later it also shows as a missing or extra `res_valid` pulse. A wrong endian set, lane mapping, sign rule or alignment mask corrupts `res_data` or `res_addr` in the cycle after the request. Every request is therefore compared in that cycle. The stimulus covers every space number in the two sets and each size, under both privilege states. A stuck valid register shows as a pulse longer than one cycle, and the bench checks for that directly.

// File: rtl/asi_fmt_pkg.sv
package asi_fmt_pkg;

   localparam int SPACE_W = 8;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_DBL  = 2'd3
   } acc_size_e;

   localparam logic [SPACE_W-1:0] PRIV_FLOOR = 8'h80;
   localparam logic [SPACE_W-1:0] HYP_FLOOR  = 8'h30;

   // little-endian membership; stores exclude the two no-fault LE spaces
   function automatic logic space_is_le(input logic [SPACE_W-1:0] sp, input logic is_store);
      logic hit;
      case (sp)
         8'h0C, 8'h18, 8'h19, 8'h1C, 8'h1D, 8'h88, 8'h89: hit = 1'b1;
         8'h8A, 8'h8B:                                    hit = !is_store;
         default:                                         hit = 1'b0;
      endcase
      return hit;
   endfunction

   function automatic logic space_is_bypass(input logic [SPACE_W-1:0] sp);
      return (sp == 8'h14) || (sp == 8'h15) || (sp == 8'h1C) || (sp == 8'h1D);
   endfunction

endpackage

// File: rtl/asi_priv_gate.sv
module asi_priv_gate
   import asi_fmt_pkg::*;
#(
   parameter bit HYP_CHECK_EN = 1'b1
) (
   input  logic               valid_i,
   input  logic [SPACE_W-1:0] space_i,
   input  logic               sup_i,
   input  logic               hyp_i,
   output logic               trap_o
);
   logic low_space;
   logic hyp_space;
   logic hyp_fault;

   assign low_space = (space_i < PRIV_FLOOR);

   generate
      if (HYP_CHECK_EN) begin : g_hyp
         assign hyp_space = (space_i >= HYP_FLOOR) && low_space;
         assign hyp_fault = hyp_space && !hyp_i;
      end else begin : g_nohyp
         assign hyp_space = 1'b0;
         assign hyp_fault = 1'b0;
      end
   endgenerate

   assign trap_o = valid_i && ((low_space && !sup_i) || hyp_fault);

   always_comb begin
      if (valid_i && !low_space)
         AST_HIGH_SPACE_FREE: assert (!trap_o); // R2
   end
endmodule

// File: rtl/asi_lane_swap.sv
module asi_lane_swap
   import asi_fmt_pkg::*;
#(
   parameter int DATA_W = 64
) (
   input  logic [DATA_W-1:0] data_i,
   input  logic [1:0]        size_i,
   input  logic              swap_i,
   output logic [DATA_W-1:0] data_o
);
   localparam int LANES = DATA_W / 8;

   generate
      if (DATA_W != 64) begin : g_bad_width
         $error("asi_lane_swap: DATA_W must be 64");
      end
   endgenerate

   logic [3:0] nbytes;
   assign nbytes = 4'(1) << size_i;

   genvar li;
   generate
      for (li = 0; li < LANES; li++) begin : g_lane
         logic [3:0] src;
         always_comb begin
            src = swap_i ? (nbytes - 4'd1 - 4'(li)) : 4'(li);
            if (4'(li) >= nbytes)
               data_o[li*8 +: 8] = 8'h00;
            else
               data_o[li*8 +: 8] = data_i[src[2:0]*8 +: 8];
         end
      end
   endgenerate

   always_comb begin
      if (size_i == SZ_BYTE)
         AST_BYTE_UNSWAPPED: assert (data_o[7:0] == data_i[7:0]); // R7
   end
endmodule

// File: rtl/asi_sign_ext.sv
module asi_sign_ext
   import asi_fmt_pkg::*;
#(
   parameter int DATA_W = 64
) (
   input  logic [DATA_W-1:0] data_i,
   input  logic [1:0]        size_i,
   input  logic              ext_i,
   output logic [DATA_W-1:0] data_o
);
   always_comb begin
      data_o = data_i;
      if (ext_i) begin
         case (size_i)
            SZ_BYTE: data_o = {{(DATA_W-8){data_i[7]}},   data_i[7:0]};
            SZ_HALF: data_o = {{(DATA_W-16){data_i[15]}}, data_i[15:0]};
            SZ_WORD: data_o = {{(DATA_W-32){data_i[31]}}, data_i[31:0]};
            default: data_o = data_i;
         endcase
      end
   end

   always_comb begin
      if (size_i == SZ_DBL)
         AST_DBL_NOT_EXTENDED: assert (data_o == data_i); // R8
   end
endmodule

// File: rtl/asi_access_fmt.sv
module asi_access_fmt
   import asi_fmt_pkg::*;
#(
   parameter int ADDR_W       = 64,
   parameter int DATA_W       = 64,
   parameter bit HYP_CHECK_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_store,
   input  logic [7:0]        req_space,
   input  logic [1:0]        req_size,
   input  logic              req_signed,
   input  logic              priv_sup,
   input  logic              priv_hyp,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_data,
   output logic              trap_priv,
   output logic              res_valid,
   output logic              res_store,
   output logic              res_phys,
   output logic [ADDR_W-1:0] res_addr,
   output logic [DATA_W-1:0] res_data
);
   localparam int ALIGN_BITS = 3;

   generate
      if (ADDR_W < ALIGN_BITS + 1) begin : g_bad_addr
         $error("asi_access_fmt: ADDR_W too small");
      end
   endgenerate

   logic              le_sel;
   logic              ext_sel;
   logic [DATA_W-1:0] swapped;
   logic [DATA_W-1:0] formatted;
   logic [ADDR_W-1:0] align_mask;
   logic [ADDR_W-1:0] addr_next;

   asi_priv_gate #(.HYP_CHECK_EN(HYP_CHECK_EN)) u_priv (
      .valid_i (req_valid),
      .space_i (req_space),
      .sup_i   (priv_sup),
      .hyp_i   (priv_hyp),
      .trap_o  (trap_priv)
   );

   assign le_sel  = space_is_le(req_space, req_store);
   assign ext_sel = !req_store && req_signed;

   asi_lane_swap #(.DATA_W(DATA_W)) u_swap (
      .data_i (req_data),
      .size_i (req_size),
      .swap_i (le_sel),
      .data_o (swapped)
   );

   asi_sign_ext #(.DATA_W(DATA_W)) u_ext (
      .data_i (swapped),
      .size_i (req_size),
      .ext_i  (ext_sel),
      .data_o (formatted)
   );

   assign align_mask = ~((ADDR_W'(1) << req_size) - ADDR_W'(1));
   assign addr_next  = req_store ? (req_addr & align_mask) : req_addr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_valid <= 1'b0;
         res_store <= 1'b0;
         res_phys  <= 1'b0;
         res_addr  <= '0;
         res_data  <= '0;
      end else begin
         res_valid <= req_valid && !trap_priv;
         if (req_valid && !trap_priv) begin
            res_store <= req_store;
            res_phys  <= req_store && space_is_bypass(req_space);
            res_addr  <= addr_next;
            res_data  <= formatted;
         end
      end
   end

   AST_TRAP_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |-> !trap_priv); // R3
   AST_TRAP_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && trap_priv) |=> !res_valid); // R3
   AST_OK_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !trap_priv) |=> res_valid); // R4
   AST_STORE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_store) |-> (res_addr[0] == 1'b0 || $past(req_size) == SZ_BYTE)); // R10
   AST_LOAD_NOT_PHYS: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && !res_store) |-> !res_phys); // R11
endmodule

// File: tb/asi_access_fmt_tb_top.sv
`timescale 1ns/1ps
module asi_access_fmt_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_store = 1'b0, req_signed = 1'b0;
   logic [7:0]  req_space = '0;
   logic [1:0]  req_size = '0;
   logic        priv_sup = 1'b0, priv_hyp = 1'b0;
   logic [63:0] req_addr = '0, req_data = '0;
   logic        trap_priv, res_valid, res_store, res_phys;
   logic [63:0] res_addr, res_data;

   int n_chk = 0, n_bad = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   asi_access_fmt dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
      .req_space(req_space), .req_size(req_size), .req_signed(req_signed),
      .priv_sup(priv_sup), .priv_hyp(priv_hyp), .req_addr(req_addr),
      .req_data(req_data), .trap_priv(trap_priv), .res_valid(res_valid),
      .res_store(res_store), .res_phys(res_phys), .res_addr(res_addr),
      .res_data(res_data)
   );

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic bit m_le(input logic [7:0] s, input bit st);
      case (s)
         8'h0C, 8'h18, 8'h19, 8'h1C, 8'h1D, 8'h88, 8'h89: return 1'b1;
         8'h8A, 8'h8B: return !st;
         default: return 1'b0;
      endcase
   endfunction

   function automatic bit m_trap(input logic [7:0] s, input bit sup, input bit hyp);
      return (s < 8'h80 && !sup) || (s >= 8'h30 && s < 8'h80 && !hyp);
   endfunction

   function automatic logic [63:0] m_data(input logic [63:0] d, input int sz, input bit le,
                                          input bit sgn, input bit st);
      int n = 1 << sz;
      logic [63:0] r = '0;
      for (int i = 0; i < n; i++)
         r[i*8 +: 8] = le ? d[(n-1-i)*8 +: 8] : d[i*8 +: 8];
      if (sgn && !st && n < 8 && r[n*8-1])
         for (int i = n*8; i < 64; i++) r[i] = 1'b1;
      return r;
   endfunction

   task automatic do_req(input bit st, input logic [7:0] sp, input int sz, input bit sgn,
                         input bit sup, input bit hyp, input logic [63:0] a,
                         input logic [63:0] d, input string tag);
      bit tr, le;
      logic [63:0] ea;
      @(negedge clk);
      req_valid = 1'b1; req_store = st; req_space = sp; req_size = 2'(sz);
      req_signed = sgn; priv_sup = sup; priv_hyp = hyp; req_addr = a; req_data = d;
      tr = m_trap(sp, sup, hyp);
      le = m_le(sp, st);
      #1;
      check({tag, " R1 R2 R3 trap"}, 64'(trap_priv), 64'(tr));
      @(negedge clk);
      req_valid = 1'b0;
      check({tag, " R3 R4 valid"}, 64'(res_valid), 64'(!tr));
      if (!tr) begin
         ea = st ? (a & ~((64'd1 << sz) - 64'd1)) : a;
         check({tag, " R4 dir"}, 64'(res_store), 64'(st));
         check({tag, " R5 R6 R7 R8 R9 data"}, res_data, m_data(d, sz, le, sgn, st));
         check({tag, " R10 addr"}, res_addr, ea);
         check({tag, " R11 phys"}, 64'(res_phys),
               64'(st && (sp == 8'h14 || sp == 8'h15 || sp == 8'h1C || sp == 8'h1D)));
      end
   endtask

   task automatic report();
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   endtask

   initial begin
      for (int c = 0; c < 100000; c++) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      report();
   end

   initial begin
      logic [7:0] sp;
      void'($urandom(32'h5A17));
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R12 valid", 64'(res_valid), 64'd0);
      check("R12 data", res_data, 64'd0);
      check("R12 addr", res_addr, 64'd0);
      check("R12 phys", 64'(res_phys), 64'd0);
      check("R12 store", 64'(res_store), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      // directed corners
      do_req(0, 8'h20, 3, 0, 0, 1, 64'h10, 64'h1, "R1");
      do_req(0, 8'h40, 3, 0, 1, 0, 64'h10, 64'h1, "R2");
      do_req(0, 8'h7F, 3, 0, 1, 1, 64'h10, 64'h1, "R2");
      do_req(0, 8'h80, 3, 0, 0, 0, 64'h10, 64'h1, "R2");
      do_req(0, 8'h88, 1, 0, 0, 0, 64'h0, 64'hFFFF_FFFF_FFFF_1234, "R5");
      do_req(0, 8'h8A, 3, 0, 0, 0, 64'h0, 64'h0102_0304_0506_0708, "R5");
      do_req(1, 8'h8A, 2, 0, 0, 0, 64'h7, 64'hAABB_CCDD, "R6");
      do_req(1, 8'h89, 2, 0, 0, 0, 64'h7, 64'hAABB_CCDD, "R6");
      do_req(0, 8'h0C, 0, 0, 1, 1, 64'h3, 64'h1234_5678_9ABC_DEF0, "R7");
      do_req(0, 8'h80, 2, 1, 0, 0, 64'h4, 64'h0000_0000_8000_0001, "R8");
      do_req(0, 8'h80, 3, 1, 0, 0, 64'h4, 64'h8000_0000_0000_0001, "R8");
      do_req(0, 8'h88, 1, 1, 0, 0, 64'h2, 64'h0000_0000_0000_0080, "R9");
      do_req(1, 8'h1D, 3, 1, 1, 1, 64'hFF, 64'h8000_0000_0000_0080, "R10");
      do_req(1, 8'h14, 1, 0, 1, 1, 64'h3, 64'h55, "R11");
      do_req(0, 8'h14, 1, 0, 1, 1, 64'h3, 64'h55, "R11");
      @(negedge clk);
      check("R4 single pulse", 64'(res_valid), 64'd0);
      // constrained random
      for (int k = 0; k < 600; k++) begin
         case ($urandom % 4)
            0: sp = 8'($urandom);
            1: begin
               case ($urandom % 9)
                  0: sp = 8'h0C; 1: sp = 8'h18; 2: sp = 8'h19; 3: sp = 8'h1C;
                  4: sp = 8'h1D; 5: sp = 8'h88; 6: sp = 8'h89; 7: sp = 8'h8A;
                  default: sp = 8'h8B;
               endcase
            end
            2: sp = 8'h80 | 8'($urandom % 16);
            default: sp = 8'h10 | 8'($urandom % 16);
         endcase
         do_req(bit'($urandom), sp, int'($urandom % 4), bit'($urandom),
                ($urandom % 4) != 0, ($urandom % 3) != 0,
                {$urandom, $urandom}, {$urandom, $urandom}, "rand");
      end
      report();
   end
endmodule